// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a first-level (directory) entry and then a second-level (table) entry from memory. A caller presents the address with two qualifiers: whether the access is a write and whether it comes from user mode. The block fetches the entries one at a time through a read port. Each read is a one-cycle request pulse, and the data comes back later with a valid strobe. The result is either a physical address or a fault with a three-bit cause code.

The directory's 4 KiB frame number comes from an input. A successful walk marks both entries as accessed, and marks the table entry dirty on a write. These updates go out through a fire-and-forget write port before the response is given. Only one translation is handled at a time. The ready output stays low from acceptance until the response cycle.

Top module: `pt_walker`

## Requirements
- R1: Entry addresses are formed from a frame number, an index and two zero bits. The directory slot is {root_frame, va[31:22], 2'b00}. The table slot is {dir_entry[31:12], va[21:12], 2'b00}.
- R2: If the directory entry has bit 0 (present) clear, the walk ends with a fault whose cause bit 0 is 0, and no table entry is read.
- R3: If the table entry has bit 0 clear, the walk ends with a not-present fault (cause bit 0 = 0). All other flag bits of an absent entry are ignored.
- R4: On success, resp_paddr = {table_entry[31:12], va[11:0]} and resp_fault = 0.
- R5: A write that meets an entry at either level with bit 1 (writable) clear ends in a protection fault (cause bit 0 = 1).
- R6: A user-mode access that meets an entry at either level with bit 2 (user) clear ends in a protection fault (cause bit 0 = 1).
- R7: The fault cause is {user, write, protection}. Bit 2 is the user-mode flag of the request, bit 1 is the write flag, and bit 0 is set for a protection violation and clear for not-present.
- R8: After a successful walk, and before the response, any entry whose bit 5 (accessed) is clear is written back with it set. On a write, the table entry also gets bit 6 (dirty) set. An entry that needs no change is not written.
- R9: A walk that faults writes nothing to memory.
- R10: req_ready is low from the cycle after acceptance until the cycle after the one-cycle resp_valid pulse. A request offered while busy is not taken.
- R11: After reset, req_ready is 1 and resp_valid, mem_rd_req and mem_wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| root_frame | input | 20 | Frame number of the directory |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| mem_wr_en | output | 1 | Entry write-back strobe |
| mem_wr_addr | output | 32 | Byte address of the write-back |
| mem_wr_data | output | 32 | Updated entry |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_fault | output | 1 | Result is a fault |
| resp_cause | output | 3 | Fault cause {user, write, protection} |
| resp_paddr | output | 32 | Physical address (zero on fault) |

## Verification
The response pulse of one translation and the offer of the next request can fall in the same cycle. This happens because the caller sees resp_valid while its next request is already waiting. The bench provokes this by holding req_valid high through a whole walk and switching the address after acceptance. It judges the outcome in three ways. The result must belong to the first address. Only two reads may occur. The pending request must not be taken until req_ready has risen again.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int OFS_W     = 12;
  localparam int IDX_W     = 10;
  localparam int SLOT_LOG  = OFS_W - IDX_W;
  localparam int FRAME_W   = VA_W - OFS_W;
  localparam int CAUSE_W   = 3;

  localparam int FL_P = 0;
  localparam int FL_W = 1;
  localparam int FL_U = 2;
  localparam int FL_A = 5;
  localparam int FL_D = 6;

  typedef logic [VA_W-1:0] word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_WT, S_TBL_RD, S_TBL_WT, S_WB_DIR, S_WB_TBL, S_RESP
  } walk_st_t;

  function automatic word_t slot_addr(input logic [FRAME_W-1:0] frame,
                                      input logic [IDX_W-1:0] idx);
    return {frame, idx, {SLOT_LOG{1'b0}}};
  endfunction

  function automatic word_t join_paddr(input logic [FRAME_W-1:0] frame,
                                       input logic [OFS_W-1:0] ofs);
    return {frame, ofs};
  endfunction
endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [FL_U:0] flags,
  input  logic          is_wr,
  input  logic          is_usr,
  output logic          present,
  output logic          prot_ok
);
  always_comb begin
    present = flags[FL_P];
    prot_ok = !(is_wr && !flags[FL_W]) && !(is_usr && !flags[FL_U]);
  end
endmodule

// File: rtl/ptw_flag_update.sv
module ptw_flag_update
  import ptw_pkg::*;
#(
  parameter bit LEAF = 1'b0
) (
  input  word_t ent,
  input  logic  is_wr,
  output logic  need,
  output word_t upd
);
  always_comb begin
    upd = ent;
    upd[FL_A] = 1'b1;
    if (LEAF && is_wr) upd[FL_D] = 1'b1;
    need = (upd != ent);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               mem_rd_req,
  output logic [VA_W-1:0]    mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [VA_W-1:0]    mem_rd_data,
  output logic               mem_wr_en,
  output logic [VA_W-1:0]    mem_wr_addr,
  output logic [VA_W-1:0]    mem_wr_data,
  output logic               resp_valid,
  output logic               resp_fault,
  output logic [CAUSE_W-1:0] resp_cause,
  output logic [VA_W-1:0]    resp_paddr
);
  localparam int LEVELS = 2;

  walk_st_t st;
  word_t    v_addr, dir_slot, tbl_slot;
  logic     v_wr, v_usr, fault, wb_seen;
  logic [CAUSE_W-1:0] cause;
  word_t    lvl_ent  [LEVELS];
  word_t    lvl_upd  [LEVELS];
  logic     lvl_need [LEVELS];

  // named events for the checks
  logic ent_present, ent_prot_ok, waiting, ent_arrive, ent_absent, ent_denied;

  ptw_entry_check u_check (
    .flags   (mem_rd_data[FL_U:0]),
    .is_wr   (v_wr),
    .is_usr  (v_usr),
    .present (ent_present),
    .prot_ok (ent_prot_ok)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    ptw_flag_update #(.LEAF(g == LEVELS-1)) u_upd (
      .ent   (lvl_ent[g]),
      .is_wr (v_wr),
      .need  (lvl_need[g]),
      .upd   (lvl_upd[g])
    );
  end

  always_comb begin
    waiting    = (st == S_DIR_WT) || (st == S_TBL_WT);
    ent_arrive = waiting && mem_rd_valid;
    ent_absent = ent_arrive && !ent_present;
    ent_denied = ent_arrive && ent_present && !ent_prot_ok;

    req_ready   = (st == S_IDLE);
    mem_rd_req  = (st == S_DIR_RD) || (st == S_TBL_RD);
    mem_rd_addr = (st == S_TBL_RD) ? tbl_slot : dir_slot;

    mem_wr_en   = ((st == S_WB_DIR) && lvl_need[0]) || ((st == S_WB_TBL) && lvl_need[1]);
    mem_wr_addr = (st == S_WB_TBL) ? tbl_slot : dir_slot;
    mem_wr_data = (st == S_WB_TBL) ? lvl_upd[1] : lvl_upd[0];

    resp_valid  = (st == S_RESP);
    resp_fault  = fault;
    resp_cause  = cause;
    resp_paddr  = fault ? '0 : join_paddr(lvl_ent[1][VA_W-1:OFS_W], v_addr[OFS_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      v_addr     <= '0;
      v_wr       <= 1'b0;
      v_usr      <= 1'b0;
      dir_slot   <= '0;
      tbl_slot   <= '0;
      lvl_ent[0] <= '0;
      lvl_ent[1] <= '0;
      fault      <= 1'b0;
      cause      <= '0;
      wb_seen    <= 1'b0;
    end else begin
      if (mem_wr_en) wb_seen <= 1'b1;
      unique case (st)
        S_IDLE: if (req_valid) begin
          v_addr   <= req_vaddr;
          v_wr     <= req_write;
          v_usr    <= req_user;
          dir_slot <= slot_addr(root_frame, req_vaddr[VA_W-1 -: IDX_W]);
          fault    <= 1'b0;
          cause    <= '0;
          wb_seen  <= 1'b0;
          st       <= S_DIR_RD;
        end
        S_DIR_RD: st <= S_DIR_WT;
        S_DIR_WT: if (ent_arrive) begin
          lvl_ent[0] <= mem_rd_data;
          if (ent_absent || ent_denied) begin
            fault <= 1'b1;
            cause <= {v_usr, v_wr, ent_denied};
            st    <= S_RESP;
          end else begin
            tbl_slot <= slot_addr(mem_rd_data[VA_W-1:OFS_W], v_addr[OFS_W +: IDX_W]);
            st       <= S_TBL_RD;
          end
        end
        S_TBL_RD: st <= S_TBL_WT;
        S_TBL_WT: if (ent_arrive) begin
          lvl_ent[1] <= mem_rd_data;
          if (ent_absent || ent_denied) begin
            fault <= 1'b1;
            cause <= {v_usr, v_wr, ent_denied};
            st    <= S_RESP;
          end else begin
            st <= S_WB_DIR;
          end
        end
        S_WB_DIR: st <= S_WB_TBL;
        S_WB_TBL: st <= S_RESP;
        S_RESP:   st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready)); // R10
  AST_DIR_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_absent && st == S_DIR_WT) |=> (resp_valid && resp_fault && !resp_cause[0] && !mem_rd_req)); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_paddr[OFS_W-1:0] == v_addr[OFS_W-1:0])); // R4
  AST_CAUSE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_cause[2] == v_usr && resp_cause[1] == v_wr)); // R7
  AST_NO_WB_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> !wb_seen); // R9
  AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && st == S_WB_TBL && v_wr) |-> (mem_wr_data[FL_D] && mem_wr_data[FL_A])); // R8
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  localparam int LAT = 2;
  localparam logic [19:0] ROOT = 20'h00100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, mem_rd_req, mem_rd_valid, mem_wr_en, resp_valid, resp_fault;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data, resp_paddr;
  logic [2:0] resp_cause;

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .root_frame(ROOT), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_cause(resp_cause), .resp_paddr(resp_paddr)
  );

  // memory model
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_hold = '0;
  int rd_cnt = 0, n_rd = 0, n_wr = 0;
  initial begin mem_rd_valid = 1'b0; mem_rd_data = '0; end

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (rd_cnt != 0) begin
      if (rd_cnt == 1) begin mem_rd_valid <= 1'b1; mem_rd_data <= peek(rd_hold); end
      rd_cnt = rd_cnt - 1;
    end
    if (mem_rd_req) begin rd_hold = mem_rd_addr; rd_cnt = LAT; n_rd = n_rd + 1; end
    if (mem_wr_en) begin mem[mem_wr_addr] = mem_wr_data; n_wr = n_wr + 1; end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va; logic wr; logic usr; logic [31:0] pde; logic [31:0] pte;
    logic flt; logic [2:0] cause; logic [31:0] pa; logic [1:0] nrd; logic [1:0] nwr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{32'h0040_1234, 1'b0, 1'b0, 32'h0020_0003, 32'h0ABC_D001, 1'b0, 3'd0, 32'h0ABC_D234, 2'd2, 2'd2},
    '{32'h0080_2ABC, 1'b1, 1'b0, 32'h0020_1007, 32'h1234_5003, 1'b0, 3'd0, 32'h1234_5ABC, 2'd2, 2'd2},
    '{32'h00C0_0000, 1'b0, 1'b1, 32'h0000_0000, 32'h0CCC_C007, 1'b1, 3'd4, 32'h0,         2'd1, 2'd0},
    '{32'h0100_3010, 1'b1, 1'b0, 32'h0020_2003, 32'h5555_5006, 1'b1, 3'd2, 32'h0,         2'd2, 2'd0},
    '{32'h0140_4000, 1'b1, 1'b0, 32'h0020_3003, 32'h0777_7001, 1'b1, 3'd3, 32'h0,         2'd2, 2'd0},
    '{32'h0180_0FFF, 1'b0, 1'b1, 32'h0020_4003, 32'h0888_8007, 1'b1, 3'd5, 32'h0,         2'd1, 2'd0},
    '{32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0020_5067, 32'h0999_9067, 1'b0, 3'd0, 32'h0999_9FFF, 2'd2, 2'd0},
    '{32'h01C0_5000, 1'b1, 1'b1, 32'h0020_6005, 32'h0AAA_A007, 1'b1, 3'd7, 32'h0,         2'd1, 2'd0},
    '{32'h0200_6000, 1'b1, 1'b0, 32'h0020_7023, 32'h0BBB_B023, 1'b0, 3'd0, 32'h0BBB_B000, 2'd2, 2'd1}
  };

  function automatic logic [31:0] dir_at(input logic [31:0] va);
    return {ROOT, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] tbl_at(input logic [31:0] pde, input logic [31:0] va);
    return {pde[31:12], va[21:12], 2'b00};
  endfunction

  logic        got_flt;
  logic [2:0]  got_cause;
  logic [31:0] got_pa;

  task automatic run_req(input logic [31:0] va, input logic wr, input logic usr);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    got_flt = resp_fault; got_cause = resp_cause; got_pa = resp_paddr;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1, "R11", "ready after reset", {31'b0, req_ready}, 32'h1);
    chk(resp_valid === 1'b0 && mem_rd_req === 1'b0 && mem_wr_en === 1'b0, "R11",
        "idle strobes after reset", {29'b0, resp_valid, mem_rd_req, mem_wr_en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      logic [31:0] da = dir_at(v.va);
      logic [31:0] ta = tbl_at(v.pde, v.va);
      logic [31:0] exp_pde, exp_pte;
      mem.delete();
      mem[da] = v.pde;
      mem[ta] = v.pte;
      n_rd = 0; n_wr = 0;
      run_req(v.va, v.wr, v.usr);
      // R1 R4: paddr correct only if both slots addressed as stated
      chk(got_flt === v.flt, "R1 R3 R5 R6", $sformatf("row %0d fault", i), {31'b0, got_flt}, {31'b0, v.flt});
      chk(got_pa === v.pa, "R4", $sformatf("row %0d paddr", i), got_pa, v.pa);
      if (v.flt)
        chk(got_cause === v.cause, "R7", $sformatf("row %0d cause", i), {29'b0, got_cause}, {29'b0, v.cause});
      chk(n_rd == v.nrd, "R2", $sformatf("row %0d reads", i), n_rd, v.nrd);
      chk(n_wr == v.nwr, "R8 R9", $sformatf("row %0d writes", i), n_wr, v.nwr);
      exp_pde = v.flt ? v.pde : (v.pde | 32'h20);
      exp_pte = v.flt ? v.pte : (v.pte | 32'h20 | (v.wr ? 32'h40 : 32'h0));
      chk(peek(da) === exp_pde, "R8", $sformatf("row %0d dir entry", i), peek(da), exp_pde);
      chk(peek(ta) === exp_pte, "R8", $sformatf("row %0d table entry", i), peek(ta), exp_pte);
    end

    // R10: request held through the walk, address changed after acceptance
    mem.delete();
    mem[dir_at(32'h0040_1234)] = 32'h0020_0003;
    mem[tbl_at(32'h0020_0003, 32'h0040_1234)] = 32'h0ABC_D001;
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_vaddr = 32'h0040_1234; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = 32'h0080_2000;
    chk(req_ready === 1'b0, "R10", "ready low while busy", {31'b0, req_ready}, 32'h0);
    while (!resp_valid) @(negedge clk);
    chk(resp_fault === 1'b0 && resp_paddr === 32'h0ABC_D234, "R10", "busy request ignored",
        resp_paddr, 32'h0ABC_D234);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "ready back after response", {31'b0, req_ready}, 32'h1);
    chk(n_rd == 2, "R10", "single walk reads", n_rd, 32'd2);
    repeat (6) @(negedge clk);
    chk(n_rd == 2 && req_ready === 1'b1, "R10", "no second walk started", n_rd, 32'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule